// File: doc/BRIEF.md
# Run-Merging Histogram Updater

This block builds a histogram from a stream of bin indices. One index can arrive on every clock cycle. A plain read-modify-write of the counter storage at that rate breaks when the same bin shows up on two cycles in a row, because the second read would see a stale value. The block avoids this by keeping the count of the current run of identical bins in a register. The storage is touched only when the bin changes, and once more to write back the open run after the beat flagged as last.

When a new run begins, the block reads the stored counter of the new bin, adds one, and continues counting in the register. For this reason a later stream adds onto the counts left by earlier streams. All counters are cleared by reset. A separate combinational readout port returns the stored counter of any bin. It reflects every write made up to the most recent clock edge.

Top module: `hist_run_merge`

## Requirements
- R1: Synchronous reset (rst high) clears every stored counter to zero, as seen on the readout port.
- R2: Once a stream has ended and its write-back is done, each counter equals its previous value plus the number of valid beats that carried that bin. Bin indices must be below VALUE_SIZE.
- R3: While consecutive valid beats carry the same bin, the stored counter of that bin shown on the readout port keeps the value it had before the run started.
- R4: A valid beat whose bin differs from the open run's bin causes the run total to be stored at the old bin. The readout port shows it from the first cycle after that beat.
- R5: After a beat with in_last high, the open run total is stored in the following cycle. The readout port shows it from the second cycle after the last beat.
- R6: A beat is accepted on every cycle with in_valid high, with no back-pressure. Back-to-back beats, including alternating bins, are all counted.
- R7: A new stream adds onto the counts left by earlier streams; counters are not cleared between streams.
- R8: A beat that arrives in the cycle right after a last beat is counted correctly, whether its bin equals or differs from the bin being written back.
- R9: Cycles with in_valid low neither close the open run nor write the storage, unless a write-back after a last beat is due.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset, clears all counters |
| in_valid | input | 1 | A bin index is presented this cycle |
| in_last | input | 1 | This beat ends the stream; write-back follows |
| in_bin | input | BIN_W | Bin index, below VALUE_SIZE |
| rd_bin | input | BIN_W | Bin selected for readout |
| rd_count | output | CNT_W | Stored counter of rd_bin, 32-bit, wraps on overflow |

## Verification
A wrong run register does not show up at the readout port while the run is still open. It appears when that run is written: in the cycle after a bin change, or two cycles after the last beat. At that point one bin holds a total that is off by the lost or duplicated counts. A bad forwarding choice in the cycle after a last beat corrupts only the bin that restarts there, and it becomes visible once that next run is written back. A bad reset or write decode shows up as a wrong value on an unrelated bin. For this reason every bin is read out after each quiescent point.

// File: rtl/hist_pkg.sv
package hist_pkg;

    localparam int CNT_W = 32;

    typedef logic [CNT_W-1:0] count_t;

    function automatic int bin_width(input int n_bins);
        return (n_bins <= 2) ? 1 : $clog2(n_bins);
    endfunction

    function automatic count_t bump(input count_t c);
        return c + count_t'(1);
    endfunction

endpackage

// File: rtl/hist_counter_bank.sv
module hist_counter_bank
    import hist_pkg::*;
#(
    parameter int VALUE_SIZE = 16,
    localparam int BIN_W = bin_width(VALUE_SIZE)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [BIN_W-1:0] wr_bin,
    input  count_t           wr_cnt,
    input  logic [BIN_W-1:0] upd_bin,
    output count_t           upd_cnt,
    input  logic [BIN_W-1:0] dump_bin,
    output count_t           dump_cnt
);

    count_t cnt_q [VALUE_SIZE];
    logic   any_set;

    for (genvar g = 0; g < VALUE_SIZE; g++) begin : g_bin
        always_ff @(posedge clk) begin
            if (rst) begin
                cnt_q[g] <= '0;
            end else if (wr_en && (wr_bin == BIN_W'(g))) begin
                cnt_q[g] <= wr_cnt;
            end
        end
    end

    always_comb begin
        upd_cnt  = cnt_q[upd_bin];
        dump_cnt = cnt_q[dump_bin];
    end

    always_comb begin
        any_set = 1'b0;
        for (int i = 0; i < VALUE_SIZE; i++) begin
            any_set = any_set | (|cnt_q[i]);
        end
    end

    // R1: the cycle after reset is released, no counter holds a value
    assert_reset_clear_R1: assert property (@(posedge clk)
        $fell(rst) |-> !any_set);

endmodule

// File: rtl/hist_run_tracker.sv
module hist_run_tracker
    import hist_pkg::*;
#(
    parameter int BIN_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_last,
    input  logic [BIN_W-1:0] in_bin,
    input  count_t           mem_cnt,
    output logic             wr_en,
    output logic [BIN_W-1:0] wr_bin,
    output count_t           wr_cnt
);

    typedef struct packed {
        logic             open;
        logic             flush;
        logic [BIN_W-1:0] bin;
        count_t           cnt;
    } run_t;

    run_t run_q, run_d;
    logic same_bin;

    always_comb begin
        same_bin = run_q.open && (in_bin == run_q.bin);
        wr_en    = run_q.open && (run_q.flush || (in_valid && !same_bin));
        wr_bin   = run_q.bin;
        wr_cnt   = run_q.cnt;
    end

    always_comb begin
        run_d = run_q;
        if (in_valid) begin
            run_d.open  = 1'b1;
            run_d.flush = in_last;
            run_d.bin   = in_bin;
            run_d.cnt   = bump(same_bin ? run_q.cnt : mem_cnt);
        end else if (run_q.flush) begin
            run_d.open  = 1'b0;
            run_d.flush = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
        end else begin
            run_q <= run_d;
        end
    end

    // R3: a continuing run never writes the storage
    assert_run_no_write_R3: assert property (@(posedge clk) disable iff (rst)
        in_valid && run_q.open && !run_q.flush && (in_bin == run_q.bin) |-> !wr_en);

    // R4: a bin change stores the old run at its own bin
    assert_change_stores_R4: assert property (@(posedge clk) disable iff (rst)
        in_valid && run_q.open && (in_bin != run_q.bin) |-> wr_en && (wr_bin == run_q.bin));

    // R5: the cycle after a last beat always writes back
    assert_flush_after_last_R5: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_last |=> wr_en);

    // R9: idle cycles without a pending write-back leave storage alone
    assert_idle_no_write_R9: assert property (@(posedge clk) disable iff (rst)
        !in_valid && !run_q.flush |-> !wr_en);

endmodule

// File: rtl/hist_run_merge.sv
module hist_run_merge
    import hist_pkg::*;
#(
    parameter int VALUE_SIZE = 16,
    localparam int BIN_W = bin_width(VALUE_SIZE)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_last,
    input  logic [BIN_W-1:0] in_bin,
    input  logic [BIN_W-1:0] rd_bin,
    output logic [CNT_W-1:0] rd_count
);

    logic             wr_en;
    logic [BIN_W-1:0] wr_bin;
    count_t           wr_cnt;
    count_t           upd_cnt;
    count_t           dump_cnt;

    hist_run_tracker #(.BIN_W(BIN_W)) u_tracker (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_last  (in_last),
        .in_bin   (in_bin),
        .mem_cnt  (upd_cnt),
        .wr_en    (wr_en),
        .wr_bin   (wr_bin),
        .wr_cnt   (wr_cnt)
    );

    hist_counter_bank #(.VALUE_SIZE(VALUE_SIZE)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_bin   (wr_bin),
        .wr_cnt   (wr_cnt),
        .upd_bin  (in_bin),
        .upd_cnt  (upd_cnt),
        .dump_bin (rd_bin),
        .dump_cnt (dump_cnt)
    );

    assign rd_count = dump_cnt;

    // R2: only legal bin indices may be presented
    assert_bin_in_range_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> (int'(in_bin) < VALUE_SIZE));

endmodule

// File: tb/sim_hist_run_merge.sv
`timescale 1ns/1ps
module sim_hist_run_merge;

    localparam int NB = 16;
    localparam int N_ROWS = 24;

    // row = {valid, last, bin[3:0]}
    localparam logic [5:0] ROWS [N_ROWS] = '{
        6'b10_0011, 6'b10_0011, 6'b10_0111, 6'b10_0011,
        6'b10_0111, 6'b00_0000, 6'b10_0111, 6'b10_1111,
        6'b10_1111, 6'b10_1111, 6'b10_0000, 6'b10_0001,
        6'b10_0000, 6'b10_0001, 6'b11_0001, 6'b10_0001,
        6'b10_1001, 6'b00_0000, 6'b00_0000, 6'b10_1001,
        6'b10_0011, 6'b10_1110, 6'b10_1110, 6'b11_0000
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_last = 1'b0;
    logic [3:0]  in_bin = '0;
    logic [3:0]  rd_bin = '0;
    logic [31:0] rd_count;

    int checks = 0;
    int errors = 0;
    int unsigned ref_cnt [NB];

    always #2 clk = ~clk;

    hist_run_merge #(.VALUE_SIZE(NB)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_last(in_last),
        .in_bin(in_bin), .rd_bin(rd_bin), .rd_count(rd_count)
    );

    task automatic beat(input logic [3:0] b, input logic l);
        @(negedge clk);
        in_valid = 1'b1; in_bin = b; in_last = l;
        ref_cnt[b] = ref_cnt[b] + 1;
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
    endtask

    task automatic check_bin(input logic [3:0] b, input int unsigned exp, input string tag);
        rd_bin = b;
        #1;
        checks++;
        if (rd_count !== exp) begin
            errors++;
            $display("FAIL %s bin %0d: got %0d expected %0d", tag, b, rd_count, exp);
        end
    endtask

    task automatic check_all(input string tag);
        for (int b = 0; b < NB; b++) begin
            check_bin(4'(b), ref_cnt[b], tag);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0; in_last = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int b = 0; b < NB; b++) ref_cnt[b] = 0;
    endtask

    initial begin
        #(4 * 100000);
        errors++;
        $display("FAIL watchdog: got hung run expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        idle();
        check_all("R1 after reset");

        // R6/R9/R2: table of back-to-back beats, gaps, and two stream ends
        for (int i = 0; i < N_ROWS; i++) begin
            if (ROWS[i][5]) beat(ROWS[i][3:0], ROWS[i][4]);
            else idle();
        end
        idle();
        idle();
        check_all("R6 R2 table");

        // R1: reset clears the accumulated table
        do_reset();
        idle();
        check_all("R1 re-reset");

        // R3: open run stays out of storage; R9: gaps keep it open
        beat(4'd2, 1'b0);
        beat(4'd2, 1'b0);
        beat(4'd2, 1'b0);
        idle();
        check_bin(4'd2, 0, "R3 run held");
        idle();
        check_bin(4'd2, 0, "R9 gap no write");
        // R4: bin change stores old run next cycle
        beat(4'd5, 1'b1);
        idle();
        check_bin(4'd2, 3, "R4 change store");
        // R5: write-back of last run one cycle later
        idle();
        check_bin(4'd5, 1, "R5 write-back");
        idle();
        check_all("R5 quiescent");

        // R7: next stream adds to stored counts
        beat(4'd2, 1'b0);
        beat(4'd2, 1'b1);
        idle();
        idle();
        check_bin(4'd2, 5, "R7 accumulate");
        check_all("R7 all");

        // R8: new stream starts in the write-back cycle, same bin
        beat(4'd4, 1'b1);
        beat(4'd4, 1'b0);
        beat(4'd4, 1'b1);
        idle();
        idle();
        check_bin(4'd4, 3, "R8 same bin");
        // R8: different bin in the write-back cycle
        beat(4'd6, 1'b1);
        beat(4'd1, 1'b1);
        beat(4'd6, 1'b1);
        idle();
        idle();
        check_bin(4'd6, 2, "R8 diff bin");
        check_all("R8 all");

        // R6: alternating bins every cycle, top bin included
        for (int i = 0; i < 20; i++) beat((i % 2 == 0) ? 4'd15 : 4'd0, i == 19);
        idle();
        idle();
        check_bin(4'd15, 10, "R6 alternate top");
        check_all("R6 alternate");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule